// File: doc/BRIEF.md
# Multi-source reset sequencer

This block generates the chip-wide system reset and its copy on the reset-out pin. Three things can trigger it: an active-low external reset pin, a one-cycle timeout pulse from the watchdog, and a one-cycle software reset request. After the last trigger goes away, the block keeps the system in reset for a fixed hold time of system clock cycles. Then it lets the system run.

A low external pin is different from the other two triggers. It drops every reset output at once, with no clock needed. It is also the only trigger that drives the separate PLL reset output. When the pin is released, the sequencer checks the synchronized PLL lock flag. If the flag is low, the sequencer waits in its own state until lock arrives, and only then starts the hold count. The watchdog and software requests can only happen while the clock is running. For that reason they go through the same hold path and never touch the PLL reset.

Top module: `rst_sequencer`

## Requirements
- R1: A low level on `ext_rst_n` drives `sys_rst_n`, `rst_out_n` and `pll_rst_n` low in the same cycle, without waiting for a clock edge.
- R2: `pll_rst_n` goes high on the 2nd rising clock edge after `ext_rst_n` rises. While `ext_rst_n` stays high it stays high, whatever `wdog_pulse` and `soft_pulse` do.
- R3: If `pll_locked` is high when `ext_rst_n` rises, `sys_rst_n` is low through the 10th rising edge after the release and goes high on the 11th. This is 2 synchronizer edges, 1 decision edge and 8 hold cycles.
- R4: If `pll_locked` is low when `ext_rst_n` rises, `sys_rst_n` stays low for as long as the lock flag stays low. After `pll_locked` rises, `sys_rst_n` goes high on the 11th rising edge.
- R5: When `wdog_pulse` is sampled high at a rising edge, `sys_rst_n` goes low at that edge and goes high again 9 edges later.
- R6: A `soft_pulse` sampled high behaves exactly like a watchdog pulse, with the same timing.
- R7: A watchdog or software pulse that arrives while the hold count is running restarts the hold. The release then happens 9 edges after the new pulse.
- R8: `rst_out_n` always equals `sys_rst_n`.
- R9: Watchdog and software pulses have no effect while `ext_rst_n` is low, or before its release has passed the synchronizer. In those cases the release timing of R3 is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_pulse | input | 1 | Watchdog timeout, one clock wide, active high |
| soft_pulse | input | 1 | Software reset request, one clock wide, active high |
| pll_locked | input | 1 | PLL lock flag, asynchronous |
| sys_rst_n | output | 1 | System reset, active low |
| rst_out_n | output | 1 | Reset-out pin, a mirror of the system reset |
| pll_rst_n | output | 1 | PLL reset, active low, driven only by the external pin |

## Verification
The release path is tested with four patterns:
- An external release with lock already present sets the baseline latency.
- An external release with lock missing, where lock arrives 20 cycles later, shows that the count waits for lock and starts only when lock appears.
- Single watchdog and software pulses confirm that the shorter internal path is used and that the PLL reset never moves.
- A second pulse placed in the middle of the hold shows that the count restarts instead of running on.

Two further cases are covered. An external assertion in the middle of a cycle, with no clock edge before the sample, shows that the reset path is asynchronous. A pulse given while the pin is held low shows that such a request is dropped.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    ST_ASSERTED  = 2'd0,
    ST_WAIT_LOCK = 2'd1,
    ST_HOLD      = 2'd2,
    ST_RUN       = 2'd3
  } rseq_state_e;

endpackage

// File: rtl/rstseq_sync.sv
// Multi-stage synchronizer, cleared asynchronously and released synchronously.
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rstseq_holdcnt.sv
// Hold-time counter: a clear input and a count enable, with a flag on the last cycle.
module rstseq_holdcnt #(
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);

  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LAST);

endmodule

// File: rtl/rstseq_fsm.sv
// Release sequencing: assert, wait for lock, hold, run.
module rstseq_fsm
  import rstseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ext_ok,     // synchronized external release
  input  logic lock_ok,    // synchronized PLL lock
  input  logic pulse,      // watchdog or software request
  input  logic cnt_done,
  output logic cnt_clr,
  output logic cnt_en,
  output logic run
);

  rseq_state_e state_q, state_d;
  logic        trig;

  assign trig = ext_ok & pulse;

  always_comb begin
    state_d = state_q;
    if (trig) begin
      state_d = ST_ASSERTED;
    end else begin
      case (state_q)
        ST_ASSERTED:  if (ext_ok) state_d = lock_ok ? ST_HOLD : ST_WAIT_LOCK;
        ST_WAIT_LOCK: if (lock_ok) state_d = ST_HOLD;
        ST_HOLD:      if (cnt_done) state_d = ST_RUN;
        ST_RUN:       state_d = ST_RUN;
        default:      state_d = ST_ASSERTED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ASSERTED;
    else        state_q <= state_d;
  end

  assign cnt_clr = (state_q != ST_HOLD);
  assign cnt_en  = (state_q == ST_HOLD);
  assign run     = (state_q == ST_RUN);

  // R7: a new request during the hold returns to the asserted state
  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && trig) |=> (state_q == ST_ASSERTED));

  // R4: without lock the hold never starts from the wait state
  a_r4_wait_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_LOCK && !lock_ok) |=> (state_q != ST_HOLD));

  // R3: entering run only after the counter reached its last value
  a_r3_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_RUN) |-> $past(cnt_done));

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic wdog_pulse,
  input  logic soft_pulse,
  input  logic pll_locked,
  output logic sys_rst_n,
  output logic rst_out_n,
  output logic pll_rst_n
);

  logic ext_sync;
  logic lock_sync;
  logic cnt_clr, cnt_en, cnt_done;
  logic run;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk   (clk),
    .rst_n (ext_rst_n),
    .d     (1'b1),
    .q     (ext_sync)
  );

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk   (clk),
    .rst_n (ext_rst_n),
    .d     (pll_locked),
    .q     (lock_sync)
  );

  rstseq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (ext_rst_n),
    .ext_ok   (ext_sync),
    .lock_ok  (lock_sync),
    .pulse    (wdog_pulse | soft_pulse),
    .cnt_done (cnt_done),
    .cnt_clr  (cnt_clr),
    .cnt_en   (cnt_en),
    .run      (run)
  );

  rstseq_holdcnt #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk   (clk),
    .rst_n (ext_rst_n),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .done  (cnt_done)
  );

  assign sys_rst_n = run;
  assign rst_out_n = run;
  assign pll_rst_n = ext_sync;

  // R2: once released, the PLL reset stays released while the pin is high
  a_r2_pll_steady: assert property (@(posedge clk) disable iff (!ext_rst_n)
    pll_rst_n |=> pll_rst_n);

  // R3: the system never runs while the PLL is still in reset
  a_r3_pll_first: assert property (@(posedge clk) disable iff (!ext_rst_n)
    sys_rst_n |-> pll_rst_n);

  // R5: a watchdog pulse after pin release resets the system
  a_r5_wdog_hits: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (wdog_pulse && pll_rst_n) |=> !sys_rst_n);

  // R6: a software pulse after pin release resets the system
  a_r6_soft_hits: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (soft_pulse && pll_rst_n) |=> !sys_rst_n);

endmodule

// File: tb/tb_rst_sequencer.sv
module tb_rst_sequencer;

  logic clk;
  logic ext_rst_n, wdog_pulse, soft_pulse, pll_locked;
  logic sys_rst_n, rst_out_n, pll_rst_n;

  int cyc;
  int checks;
  int errors;

  typedef struct {
    int    at;
    logic  sys;
    logic  pll;
    string req;
  } exp_t;

  exp_t exp_q[$];

  rst_sequencer dut (
    .clk        (clk),
    .ext_rst_n  (ext_rst_n),
    .wdog_pulse (wdog_pulse),
    .soft_pulse (soft_pulse),
    .pll_locked (pll_locked),
    .sys_rst_n  (sys_rst_n),
    .rst_out_n  (rst_out_n),
    .pll_rst_n  (pll_rst_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int at, input logic sys, input logic pll, input string req);
    exp_t e;
    e.at = at; e.sys = sys; e.pll = pll; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // monitor: compares at the falling edge, after edge number cyc
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].at <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (sys_rst_n !== e.sys || pll_rst_n !== e.pll || rst_out_n !== sys_rst_n) begin
        errors++;
        $display("FAIL %s (R8 mirror): cycle %0d sys_rst_n=%b rst_out_n=%b pll_rst_n=%b expected sys=%b out=%b pll=%b",
                 e.req, cyc, sys_rst_n, rst_out_n, pll_rst_n, e.sys, e.sys, e.pll);
      end
    end
  end

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: run did not finish, cycle %0d expected end", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e0;
    checks = 0;
    errors = 0;
    ext_rst_n  = 1'b0;
    wdog_pulse = 1'b0;
    soft_pulse = 1'b0;
    pll_locked = 1'b1;
    step(3);

    // R1: reset state with the pin low
    expect_at(cyc, 1'b0, 1'b0, "R1");
    // R9: pulses while the pin is low are dropped
    wdog_pulse = 1'b1; soft_pulse = 1'b1;
    step(1);
    wdog_pulse = 1'b0; soft_pulse = 1'b0;
    step(1);

    // R2, R3: release with lock present
    e0 = cyc;
    ext_rst_n = 1'b1;
    expect_at(e0 + 1, 1'b0, 1'b0, "R2");
    expect_at(e0 + 2, 1'b0, 1'b1, "R2");
    expect_at(e0 + 10, 1'b0, 1'b1, "R3 R9");
    expect_at(e0 + 11, 1'b1, 1'b1, "R3 R9");
    step(15);

    // R5: watchdog pulse, sampled at edge e0+1
    e0 = cyc;
    expect_at(e0, 1'b1, 1'b1, "R5");
    expect_at(e0 + 1, 1'b0, 1'b1, "R5 R2");
    expect_at(e0 + 9, 1'b0, 1'b1, "R5");
    expect_at(e0 + 10, 1'b1, 1'b1, "R5");
    wdog_pulse = 1'b1;
    step(1);
    wdog_pulse = 1'b0;
    step(12);

    // R6: software pulse
    e0 = cyc;
    expect_at(e0 + 1, 1'b0, 1'b1, "R6 R2");
    expect_at(e0 + 9, 1'b0, 1'b1, "R6");
    expect_at(e0 + 10, 1'b1, 1'b1, "R6");
    soft_pulse = 1'b1;
    step(1);
    soft_pulse = 1'b0;
    step(12);

    // R7: second request during the hold restarts it
    e0 = cyc;
    expect_at(e0 + 10, 1'b0, 1'b1, "R7");
    expect_at(e0 + 13, 1'b0, 1'b1, "R7");
    expect_at(e0 + 14, 1'b1, 1'b1, "R7");
    wdog_pulse = 1'b1;
    step(1);
    wdog_pulse = 1'b0;
    step(3);
    soft_pulse = 1'b1;
    step(1);
    soft_pulse = 1'b0;
    step(14);

    // R1: asynchronous assertion in mid-cycle while running
    e0 = cyc;
    expect_at(e0, 1'b1, 1'b1, "R1");
    step(1);
    e0 = cyc;
    ext_rst_n  = 1'b0;
    pll_locked = 1'b0;
    expect_at(e0, 1'b0, 1'b0, "R1");
    step(3);

    // R4: release without lock
    e0 = cyc;
    ext_rst_n = 1'b1;
    expect_at(e0 + 2, 1'b0, 1'b1, "R2 R4");
    expect_at(e0 + 20, 1'b0, 1'b1, "R4");
    step(20);
    e0 = cyc;
    pll_locked = 1'b1;
    expect_at(e0 + 10, 1'b0, 1'b1, "R4");
    expect_at(e0 + 11, 1'b1, 1'b1, "R4");
    step(15);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule